// File: doc/BRIEF.md
# Edge-Qualified Decade/Binary Up Counter Pair

This block holds a set of identical, independent 4-bit up counters. There are two by default. Each channel has three control pins, all asynchronous to the system clock: a count pin, a qualifier pin and a clear pin. Either of the first two can serve as the clock for that channel. A channel steps by one when the count pin rises while the qualifier pin was high before the edge. It also steps by one when the qualifier pin falls while the count pin was low before the edge. A parameter builds all channels as decade counters (0 to 9) or as modulo-16 binary counters (0 to 15).

The pins are synchronised and edge-detected inside the block, on the single system clock, so the counting runs in one clock domain. All four bits of a channel update in the same system cycle. Channels can be chained as a ripple chain. To do this, tie the most significant output bit of one channel to the qualifier pin of the next and hold that channel's count pin low. The next stage then advances each time the first one wraps to zero.

Top module: `edge_qual_counter`

## Requirements
- R1: A rising edge on a channel's count pin, while its qualifier pin was high before that edge, raises the channel's count by one.
- R2: A rising edge on the count pin while the qualifier pin was low leaves the count unchanged.
- R3: A falling edge on a channel's qualifier pin, while its count pin was low before that edge, raises the count by one.
- R4: A falling edge on the qualifier pin while the count pin was high leaves the count unchanged. Rising qualifier edges and falling count edges never change the count.
- R5: A high level on the clear pin forces the count to zero and holds it there, ignoring all edges. After the clear pin goes low, counting resumes on the next qualifying edge.
- R6: With DECADE=1 the count runs 0..9 and wraps from 9 to 0. With DECADE=0 it runs 0..15 and wraps from 15 to 0.
- R7: Each channel counts only from its own pins. Activity on one channel never changes another.
- R8: A qualifying count-pin rise and a qualifying qualifier-pin fall that are detected in the same system cycle raise the count by exactly one.
- R9: A pin level that is present at system clock edge n is reflected on the outputs after edge n+2.
- R10: Channel i drives ch_q bits [4i+3:4i], with bit 4i the least significant bit of the count.
- R11: If channel 1's qualifier pin is fed from channel 0's bit 3 and channel 1's count pin is held low, channel 1 advances once each time channel 0 wraps to zero.
- R12: A high level on rst at a system clock edge clears every channel's count to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset of the whole block |
| ch_clk | input | NCH | Per-channel count pin (asynchronous) |
| ch_en | input | NCH | Per-channel qualifier pin (asynchronous) |
| ch_clr | input | NCH | Per-channel clear pin, active high (asynchronous) |
| ch_q | output | 4*NCH | Registered counts, four bits per channel, LSB first |

## Verification
The assertions assume two things. First, the count and qualifier pins are low while rst is asserted, so releasing reset does not look like an edge. Second, each pin level lasts long enough to reach the synchronizer output. The stimulus changes pins only at the falling system clock edge. It holds each level for at least three system cycles, except in the deliberate same-cycle case of R8, and it drops every pin low before reset is applied. The cascade pin of the second channel follows the first channel's output, which changes only at a rising clock edge, so it also meets these conditions.

// File: rtl/qcnt_pkg.sv
package qcnt_pkg;

    localparam int CW = 4;

    typedef logic [CW-1:0] count_t;

    // current synchronised sample and the one taken a cycle before
    typedef struct packed {
        logic now;
        logic was;
    } lvl_t;

    typedef struct packed {
        lvl_t clk;
        lvl_t en;
        logic clr;
    } pins_t;

    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_CLK  = 2'd1,
        STEP_EN   = 2'd2,
        STEP_BOTH = 2'd3
    } step_src_e;

    function automatic logic is_rise(lvl_t l);
        return l.now & ~l.was;
    endfunction

    function automatic logic is_fall(lvl_t l);
        return ~l.now & l.was;
    endfunction

    function automatic count_t last_value(logic decade);
        return decade ? count_t'(9) : count_t'(15);
    endfunction

    function automatic count_t bump(count_t c, logic decade);
        if (c >= last_value(decade))
            return '0;
        return c + count_t'(1);
    endfunction

endpackage

// File: rtl/qcnt_sync.sv
module qcnt_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] stg;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[0] <= '0;
                else     stg[0] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= '0;
                else     stg[s] <= stg[s-1];
            end
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/qcnt_front.sv
module qcnt_front
    import qcnt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  pin_clk,
    input  logic  pin_en,
    input  logic  pin_clr,
    output pins_t view
);
    localparam int NPIN = 3;

    logic [NPIN-1:0] synced;
    logic            clk_was;
    logic            en_was;

    qcnt_sync #(
        .WIDTH  (NPIN),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({pin_clr, pin_en, pin_clk}),
        .dout (synced)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_was <= 1'b0;
            en_was  <= 1'b0;
        end else begin
            clk_was <= synced[0];
            en_was  <= synced[1];
        end
    end

    always_comb begin
        view.clk.now = synced[0];
        view.clk.was = clk_was;
        view.en.now  = synced[1];
        view.en.was  = en_was;
        view.clr     = synced[2];
    end
endmodule

// File: rtl/qcnt_qualify.sv
module qcnt_qualify
    import qcnt_pkg::*;
(
    input  pins_t     view,
    output step_src_e src,
    output logic      clear
);
    logic by_clk;
    logic by_en;

    // the qualifying level is the one held before the edge
    always_comb begin
        by_clk = is_rise(view.clk) & view.en.was;
        by_en  = is_fall(view.en) & ~view.clk.was;
        unique case ({by_en, by_clk})
            2'b01:   src = STEP_CLK;
            2'b10:   src = STEP_EN;
            2'b11:   src = STEP_BOTH;
            default: src = STEP_NONE;
        endcase
        clear = view.clr;
    end
endmodule

// File: rtl/qcnt_core.sv
module qcnt_core
    import qcnt_pkg::*;
#(
    parameter bit DECADE = 1'b1
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      clear,
    input  step_src_e src,
    output count_t    q
);
    count_t q_nxt;

    always_comb begin
        q_nxt = q;
        if (clear)
            q_nxt = '0;
        else if (src != STEP_NONE)
            q_nxt = bump(q, DECADE);
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= q_nxt;
    end
endmodule

// File: rtl/qcnt_channel.sv
module qcnt_channel
    import qcnt_pkg::*;
#(
    parameter bit DECADE      = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   pin_clk,
    input  logic   pin_en,
    input  logic   pin_clr,
    output count_t q
);
    pins_t     view;
    step_src_e src;
    logic      clear;

    qcnt_front #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_front (
        .clk     (clk),
        .rst     (rst),
        .pin_clk (pin_clk),
        .pin_en  (pin_en),
        .pin_clr (pin_clr),
        .view    (view)
    );

    qcnt_qualify u_qual (
        .view  (view),
        .src   (src),
        .clear (clear)
    );

    qcnt_core #(
        .DECADE (DECADE)
    ) u_core (
        .clk   (clk),
        .rst   (rst),
        .clear (clear),
        .src   (src),
        .q     (q)
    );
endmodule

// File: rtl/edge_qual_counter.sv
module edge_qual_counter
    import qcnt_pkg::*;
#(
    parameter int NCH    = 2,
    parameter bit DECADE = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NCH-1:0]    ch_clk,
    input  logic [NCH-1:0]    ch_en,
    input  logic [NCH-1:0]    ch_clr,
    output logic [NCH*CW-1:0] ch_q
);
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        count_t q_i;

        qcnt_channel #(
            .DECADE      (DECADE),
            .SYNC_STAGES (2)
        ) u_chan (
            .clk     (clk),
            .rst     (rst),
            .pin_clk (ch_clk[i]),
            .pin_en  (ch_en[i]),
            .pin_clr (ch_clr[i]),
            .q       (q_i)
        );

        assign ch_q[i*CW +: CW] = q_i;
    end
endmodule

// File: rtl/qcnt_checker.sv
module qcnt_checker
    import qcnt_pkg::*;
#(
    parameter int NCH    = 2,
    parameter bit DECADE = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic [NCH-1:0]    ch_clk,
    input logic [NCH-1:0]    ch_en,
    input logic [NCH-1:0]    ch_clr,
    input logic [NCH*CW-1:0] ch_q
);
    logic [2:0] age;
    logic       ready;

    always_ff @(posedge clk) begin
        if (rst)             age <= '0;
        else if (age != 3'd7) age <= age + 3'd1;
    end

    assign ready = (age >= 3'd5);

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        AST_RESET_ZERO: assert property (@(posedge clk)
            $past(rst) |-> ch_q[i*CW +: CW] == '0); // R12

        AST_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
            ch_q[i*CW +: CW] <= last_value(DECADE)); // R6

        AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
            (ready && ch_q[i*CW +: CW] != $past(ch_q[i*CW +: CW]))
            |-> (ch_q[i*CW +: CW] == '0 ||
                 ch_q[i*CW +: CW] == bump($past(ch_q[i*CW +: CW]), DECADE))); // R1

        AST_CLEAR_HOLDS: assert property (@(posedge clk) disable iff (rst)
            (ready && $past(ch_clr[i], 3)) |-> ch_q[i*CW +: CW] == '0); // R5

        AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
            (ready && $past(ch_clk[i], 3) == $past(ch_clk[i], 4)
                   && $past(ch_en[i], 3) == $past(ch_en[i], 4)
                   && !$past(ch_clr[i], 3))
            |-> ch_q[i*CW +: CW] == $past(ch_q[i*CW +: CW])); // R4
    end
endmodule

bind edge_qual_counter qcnt_checker #(
    .NCH    (NCH),
    .DECADE (DECADE)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .ch_clk (ch_clk),
    .ch_en  (ch_en),
    .ch_clr (ch_clr),
    .ch_q   (ch_q)
);

// File: tb/edge_qual_counter_tb.sv
`timescale 1ns/1ps
module edge_qual_counter_tb;
    localparam int NCH = 2;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NCH-1:0] clk_drv = '0;
    logic [NCH-1:0] en_drv  = '0;
    logic [NCH-1:0] clr_drv = '0;
    logic           cascade = 1'b0;
    logic [NCH-1:0] en_dec, en_bin;
    logic [NCH*4-1:0] q_dec, q_bin;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    checking = 1'b0;
    bit    done     = 1'b0;
    string cur_tag  = "R12";

    always #2 clk = ~clk;

    assign en_dec = {cascade ? q_dec[3] : en_drv[1], en_drv[0]};
    assign en_bin = {cascade ? q_bin[3] : en_drv[1], en_drv[0]};

    edge_qual_counter #(.NCH(NCH), .DECADE(1'b1)) u_dut (
        .clk(clk), .rst(rst), .ch_clk(clk_drv), .ch_en(en_dec),
        .ch_clr(clr_drv), .ch_q(q_dec));

    edge_qual_counter #(.NCH(NCH), .DECADE(1'b0)) u_dut_bin (
        .clk(clk), .rst(rst), .ch_clk(clk_drv), .ch_en(en_bin),
        .ch_clr(clr_drv), .ch_q(q_bin));

    // behavioural model: pin histories, index 0 = level at the latest edge
    int hc[2][NCH][4];
    int he[2][NCH][4];
    int hr[2][NCH][4];
    int mcnt[2][NCH];
    int epin[2][NCH];
    int modv[2] = '{10, 16};

    always @(posedge clk) begin
        if (rst) begin
            for (int m = 0; m < 2; m++)
                for (int c = 0; c < NCH; c++) begin
                    mcnt[m][c] = 0;
                    for (int k = 0; k < 4; k++) begin
                        hc[m][c][k] = 0; he[m][c][k] = 0; hr[m][c][k] = 0;
                    end
                end
        end else begin
            for (int m = 0; m < 2; m++)
                for (int c = 0; c < NCH; c++)
                    epin[m][c] = (c == 1 && cascade) ? ((mcnt[m][0] >> 3) & 1)
                                                     : int'(en_drv[c]);
            for (int m = 0; m < 2; m++)
                for (int c = 0; c < NCH; c++) begin
                    bit step;
                    for (int k = 3; k > 0; k--) begin
                        hc[m][c][k] = hc[m][c][k-1];
                        he[m][c][k] = he[m][c][k-1];
                        hr[m][c][k] = hr[m][c][k-1];
                    end
                    hc[m][c][0] = int'(clk_drv[c]);
                    he[m][c][0] = epin[m][c];
                    hr[m][c][0] = int'(clr_drv[c]);
                    step = (hc[m][c][2] == 1 && hc[m][c][3] == 0 && he[m][c][3] == 1) ||
                           (he[m][c][2] == 0 && he[m][c][3] == 1 && hc[m][c][3] == 0);
                    if (hr[m][c][2] == 1)  mcnt[m][c] = 0;
                    else if (step)         mcnt[m][c] = (mcnt[m][c] + 1) % modv[m];
                end
        end
    end

    // compare with the model on every clock
    always @(negedge clk) begin
        if (checking && !done) begin
            for (int m = 0; m < 2; m++)
                for (int c = 0; c < NCH; c++) begin
                    int got;
                    got = (m == 0) ? int'(q_dec[c*4 +: 4]) : int'(q_bin[c*4 +: 4]);
                    n_checks++;
                    if (got != mcnt[m][c]) begin
                        n_fail++;
                        $display("FAIL %s model inst=%0d ch=%0d actual=%0d expected=%0d",
                                 cur_tag, m, c, got, mcnt[m][c]);
                    end
                end
        end
    end

    task automatic expect_q(int m, int c, int val, string tag);
        int got;
        got = (m == 0) ? int'(q_dec[c*4 +: 4]) : int'(q_bin[c*4 +: 4]);
        n_checks++;
        if (got != val) begin
            n_fail++;
            $display("FAIL %s inst=%0d ch=%0d actual=%0d expected=%0d", tag, m, c, got, val);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_clk(int c);
        clk_drv[c] = 1'b1; idle(3);
        clk_drv[c] = 1'b0; idle(3);
    endtask

    task automatic pulse_en_fall(int c);
        en_drv[c] = 1'b1; idle(3);
        en_drv[c] = 1'b0; idle(3);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        idle(4);
        rst = 1'b0;
        checking = 1'b1;
        idle(1);
        // R12: reset state
        expect_q(0, 0, 0, "R12"); expect_q(0, 1, 0, "R12");
        expect_q(1, 0, 0, "R12"); expect_q(1, 1, 0, "R12");

        // R1: count-pin rises with qualifier high
        cur_tag = "R1";
        en_drv[0] = 1'b1; idle(3);
        for (int k = 0; k < 3; k++) pulse_clk(0);
        expect_q(0, 0, 3, "R1");
        expect_q(0, 1, 0, "R7");

        // R9: latency of two edges after sampling
        cur_tag = "R9";
        clk_drv[0] = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        expect_q(0, 0, 3, "R9");
        @(posedge clk); @(negedge clk);
        expect_q(0, 0, 4, "R9");
        clk_drv[0] = 1'b0; idle(3);

        // R3: qualifier fall with count pin low
        cur_tag = "R3";
        en_drv[0] = 1'b0; idle(4);
        expect_q(0, 0, 5, "R3");

        // R2: count-pin rises with qualifier low
        cur_tag = "R2";
        pulse_clk(0); pulse_clk(0);
        expect_q(0, 0, 5, "R2");

        // R4: qualifier toggles while count pin high, then count pin falls
        cur_tag = "R4";
        clk_drv[0] = 1'b1; idle(3);
        pulse_en_fall(0);
        clk_drv[0] = 1'b0; idle(4);
        expect_q(0, 0, 5, "R4");

        // R3 again up to 9, then R10 bit order
        cur_tag = "R3";
        for (int k = 0; k < 4; k++) pulse_en_fall(0);
        idle(2);
        expect_q(0, 0, 9, "R3");
        n_checks++;
        if (q_dec[0] !== 1'b1 || q_dec[3] !== 1'b1 || q_dec[7:4] !== 4'd0) begin
            n_fail++;
            $display("FAIL R10 actual=%b expected=00001001", q_dec);
        end

        // R6: decade wrap, then binary wrap
        cur_tag = "R6";
        pulse_en_fall(0); idle(2);
        expect_q(0, 0, 0, "R6");
        expect_q(1, 0, 10, "R6");
        for (int k = 0; k < 6; k++) pulse_en_fall(0);
        idle(2);
        expect_q(1, 0, 0, "R6");
        expect_q(0, 0, 6, "R6");

        // R8: both qualifying edges in the same cycle
        cur_tag = "R8";
        en_drv[0] = 1'b1; idle(3);
        clk_drv[0] = 1'b1; en_drv[0] = 1'b0; idle(4);
        expect_q(0, 0, 7, "R8");
        expect_q(1, 0, 1, "R8");
        clk_drv[0] = 1'b0; idle(3);

        // R5: clear holds through edges, resumes afterwards
        cur_tag = "R5";
        clr_drv[0] = 1'b1; idle(4);
        expect_q(0, 0, 0, "R5");
        for (int k = 0; k < 3; k++) pulse_en_fall(0);
        expect_q(0, 0, 0, "R5");
        expect_q(1, 0, 0, "R5");
        clr_drv[0] = 1'b0; idle(4);
        expect_q(0, 0, 0, "R5");
        pulse_en_fall(0); idle(2);
        expect_q(0, 0, 1, "R5");

        // R7: channel 1 counts alone
        cur_tag = "R7";
        en_drv[1] = 1'b1; idle(3);
        for (int k = 0; k < 2; k++) pulse_clk(1);
        en_drv[1] = 1'b0; idle(4);
        expect_q(0, 1, 3, "R7");
        expect_q(0, 0, 1, "R7");

        // R11: ripple chain from channel 0 into channel 1
        cur_tag = "R11";
        clr_drv = '1; idle(4);
        cascade = 1'b1; idle(2);
        clr_drv = '0; idle(4);
        for (int k = 0; k < 10; k++) pulse_en_fall(0);
        idle(6);
        expect_q(0, 0, 0, "R11"); expect_q(0, 1, 1, "R11");
        expect_q(1, 0, 10, "R11"); expect_q(1, 1, 0, "R11");
        for (int k = 0; k < 6; k++) pulse_en_fall(0);
        idle(6);
        expect_q(1, 0, 0, "R11"); expect_q(1, 1, 1, "R11");
        expect_q(0, 0, 6, "R11"); expect_q(0, 1, 1, "R11");

        // R12: reset mid-count
        cur_tag = "R12";
        cascade = 1'b0; idle(2);
        rst = 1'b1; idle(2);
        expect_q(0, 0, 0, "R12"); expect_q(1, 1, 0, "R12");
        rst = 1'b0; idle(4);
        finish_run();
    end
endmodule